// File: doc/BRIEF.md
# Four-Way Channel Select Controller with Interrupt Summary

This block is the digital core of a bus fan-out switch. It is an I2C target that owns one 8-bit control value. An upstream master writes the value to choose which of four downstream channels are connected. The low four bits drive four channel-enable outputs, and any combination of channels may be on at once. A new selection is held aside and only reaches the enables when the master ends the transaction with a STOP, so a channel is never connected while the bus is mid-transfer.

Four active-low interrupt lines arrive from the downstream channels. They are merged into one active-low summary output, and this output does not depend on which channels are enabled. When the master reads the control value, it gets the interrupt state of every channel in the upper four bits and the applied selection in the lower four bits. The master can then find which channel is signalling and switch to it.

SCL and SDA are brought into the system clock domain through synchronizer flops. The block drives SDA only through a pull-low enable. The 7-bit target address is a fixed 5-bit upper part, set by a parameter, followed by two bits taken from address-select pins.

Top module: `chanSelSwitch`

## Requirements
- R1: The first byte after a START is the address {ADDR_FIXED[4:0], addrSel[1:0]} in bits 7..1, MSB first, followed by a direction bit in bit 0 (1 = read, 0 = write). On a match, the block pulls SDA low through the ninth SCL clock.
- R2: If the address does not match, the block does not drive SDA for the rest of the transaction. It ignores every following byte until the next START, and the channel enables stay as they were.
- R3: In a write, the block acknowledges every data byte. When several bytes arrive in one transaction, only the last one sets the selection.
- R4: After a write that ends in STOP, chanEn[n] equals bit n of the last written byte, for n = 0..3. Any of the 16 combinations may be selected.
- R5: chanEn does not change before the STOP. After a write followed by a repeated START, the old selection stays on the outputs and is still what a read returns. The pending value is applied at the next STOP that arrives.
- R6: A read byte holds ~irqN[3:0] in bits 7..4 and chanEn[3:0] in bits 3..0, sent MSB first. The value is captured on the SCL falling edge that ends the acknowledge before that byte.
- R7: During a read, a master ACK makes the block send another freshly captured byte. A master NACK makes the block release SDA and stay quiet until the next START.
- R8: irqOutN is low whenever any bit of irqN is low, whatever the channel enables are.
- R9: While rstN is low, chanEn and any pending selection are cleared, the bus state returns to idle and SDA is released. A STOP after reset applies nothing.
- R10: The SDA pull-low enable changes only while SCL is low, so a driven bit is held through the whole SCL-high period.
- R11: A START in the middle of a byte abandons the transfer and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Upstream bus clock level |
| sdaIn | input | 1 | Upstream bus data level |
| sdaPullLow | output | 1 | When 1, the pad pulls SDA low |
| addrSel | input | 2 | Low two bits of the target address |
| irqN | input | 4 | Active-low interrupt from channels 3..0 |
| irqOutN | output | 1 | Active-low summary of all interrupt inputs |
| chanEn | output | 4 | Enable for downstream channels 3..0 |

## Verification
Bus inputs pass through two synchronizer flops and one edge-detect flop. The registered response therefore appears three to four clocks after an SCL or SDA change: for SDA drive, after a falling SCL edge, and for the channel enables, after the SDA rise that forms the STOP. The bench holds each SCL phase for six clocks and samples SDA in the middle of the high phase, so every slave response has settled before it is read. Enables are checked once the STOP sequence has finished, and checked unchanged just before the STOP. The summary output is combinational and is checked right after the interrupt inputs are set.

// File: rtl/chanSelPkg.sv
package chanSelPkg;
  localparam int BYTE_BITS = 8;
  localparam int CH_COUNT  = 4;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } busState_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic rxBit;     // value of that bit
    logic loadTx;    // capture read value into transmit register
    logic shiftTx;   // advance transmit register
    logic storePend; // received byte becomes pending selection
    logic applyPend; // STOP seen
  } dpStrobe_t;
endpackage

// File: rtl/chanSelBusCtl.sv
module chanSelBusCtl
  import chanSelPkg::*;
#(
  parameter int ADDR_PINS = 2,
  parameter logic [6-ADDR_PINS:0] ADDR_FIXED = 5'b11100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scl,
  input  logic                 sdaIn,
  input  logic [ADDR_PINS-1:0] addrSel,
  input  logic [7:0]           rxByte,
  input  logic                 readMsb,
  input  logic                 txNext,
  output dpStrobe_t            strb,
  output logic                 sdaPullLow
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic startDet, stopDet, sclRise, sclFall, addrHit;
  busState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic pullNxt, mAck, mAckNxt;

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= scl;
          sdaSync <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;
  assign addrHit  = (rxByte[7:1] == {ADDR_FIXED, addrSel});

  always_comb begin
    stateNxt   = state;
    cntNxt     = bitCnt;
    pullNxt    = sdaPullLow;
    mAckNxt    = mAck;
    strb       = '0;
    strb.rxBit = sdaS;
    if (startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      pullNxt  = 1'b0;
    end else if (stopDet) begin
      stateNxt       = ST_IDLE;
      cntNxt         = '0;
      pullNxt        = 1'b0;
      strb.applyPend = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            cntNxt       = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == CNT_W'(BYTE_BITS)) begin
            cntNxt = '0;
            if (state == ST_WR) begin
              strb.storePend = 1'b1;
              pullNxt        = 1'b1;
              stateNxt       = ST_WR_ACK;
            end else if (addrHit) begin
              pullNxt  = 1'b1;
              stateNxt = ST_ADDR_ACK;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              stateNxt    = ST_RD;
              strb.loadTx = 1'b1;
              pullNxt     = ~readMsb;
            end else begin
              stateNxt = ST_WR;
              pullNxt  = 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            stateNxt = ST_WR;
            pullNxt  = 1'b0;
          end
        end
        ST_RD: begin
          if (sclRise) begin
            cntNxt = bitCnt + CNT_W'(1);
          end else if (sclFall) begin
            if (bitCnt == CNT_W'(BYTE_BITS)) begin
              cntNxt   = '0;
              pullNxt  = 1'b0;
              stateNxt = ST_RD_ACK;
            end else begin
              strb.shiftTx = 1'b1;
              pullNxt      = ~txNext;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              stateNxt    = ST_RD;
              strb.loadTx = 1'b1;
              pullNxt     = ~readMsb;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
      mAck       <= 1'b0;
    end else begin
      state      <= stateNxt;
      bitCnt     <= cntNxt;
      sdaPullLow <= pullNxt;
      mAck       <= mAckNxt;
    end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !$past(sclS)) else $error("pull changed with SCL high"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow) else $error("idle target drives SDA"); // R2
  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sdaPullLow) else $error("ack slot not driven"); // R1
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_BITS)) else $error("bit counter overflow"); // R11
endmodule

// File: rtl/chanSelRegs.sv
module chanSelRegs
  import chanSelPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [CH_COUNT-1:0] irqN,
  output logic [7:0]          rxByte,
  output logic                readMsb,
  output logic                txNext,
  output logic [CH_COUNT-1:0] chanEn
);
  logic [BYTE_BITS-1:0] readValue;
  logic [BYTE_BITS-2:0] txRest;
  logic [CH_COUNT-1:0]  pending;
  logic                 pendValid;

  assign readValue = {~irqN, chanEn};
  assign readMsb   = readValue[BYTE_BITS-1];
  assign txNext    = txRest[BYTE_BITS-2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxByte <= '0;
    end else if (strb.shiftIn) begin
      rxByte <= {rxByte[BYTE_BITS-2:0], strb.rxBit};
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txRest <= '0;
    end else if (strb.loadTx) begin
      txRest <= readValue[BYTE_BITS-2:0];
    end else if (strb.shiftTx) begin
      txRest <= {txRest[BYTE_BITS-3:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pending   <= '0;
      pendValid <= 1'b0;
      chanEn    <= '0;
    end else if (strb.storePend) begin
      pending   <= rxByte[CH_COUNT-1:0];
      pendValid <= 1'b1;
    end else if (strb.applyPend) begin
      pendValid <= 1'b0;
      if (pendValid) chanEn <= pending;
    end

  AST_ENABLE_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEn) |-> $past(strb.applyPend)) else $error("enables changed without STOP"); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.loadTx, strb.shiftTx, strb.storePend, strb.applyPend}))
    else $error("conflicting datapath strobes"); // R3
endmodule

// File: rtl/chanSelSwitch.sv
module chanSelSwitch
  import chanSelPkg::*;
#(
  parameter int ADDR_PINS = 2,
  parameter logic [6-ADDR_PINS:0] ADDR_FIXED = 5'b11100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scl,
  input  logic                 sdaIn,
  output logic                 sdaPullLow,
  input  logic [ADDR_PINS-1:0] addrSel,
  input  logic [CH_COUNT-1:0]  irqN,
  output logic                 irqOutN,
  output logic [CH_COUNT-1:0]  chanEn
);
  dpStrobe_t  strb;
  logic [7:0] rxByte;
  logic       readMsb, txNext;

  chanSelBusCtl #(
    .ADDR_PINS  (ADDR_PINS),
    .ADDR_FIXED (ADDR_FIXED),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_busCtl (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaIn),
    .addrSel   (addrSel),
    .rxByte    (rxByte),
    .readMsb   (readMsb),
    .txNext    (txNext),
    .strb      (strb),
    .sdaPullLow(sdaPullLow)
  );

  chanSelRegs i_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irqN   (irqN),
    .rxByte (rxByte),
    .readMsb(readMsb),
    .txNext (txNext),
    .chanEn (chanEn)
  );

  assign irqOutN = &irqN;
endmodule

// File: tb/test_chanSelSwitch.sv
module test_chanSelSwitch;
  localparam logic [4:0] AFIX = 5'b11100;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'b00;
  logic [3:0] irqN = 4'hF;
  logic sdaPullLow, irqOutN, sdaBus;
  logic [3:0] chanEn;
  int checks = 0, errors = 0, pullViol = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaPullLow;

  chanSelSwitch #(.ADDR_FIXED(AFIX)) i_chanSelSwitch (
    .clk(clk), .rstN(rstN), .scl(sclDrv), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .addrSel(addrSel), .irqN(irqN), .irqOutN(irqOutN), .chanEn(chanEn)
  );

  // R10 monitor: pull enable must not move while SCL is high
  logic prevPull = 1'b0;
  always @(posedge clk) begin
    if (rstN && sdaPullLow != prevPull && sclDrv) pullViol++;
    prevPull <= sdaPullLow;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ(); sclDrv = 1'b1; waitQ(); sclDrv = 1'b0;
  endtask
  task automatic getBit(output logic b);
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ(); b = sdaBus; waitQ(); sclDrv = 1'b0;
  endtask
  task automatic busStart();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask
  task automatic busStop();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(b);
    ack = ~b;
  endtask
  task automatic getByte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin getBit(b); d[i] = b; end
  endtask

  function automatic logic [7:0] adr(input logic [1:0] pins, input logic rw);
    return {AFIX, pins, rw};
  endfunction

  initial begin
    logic ack, b;
    logic [7:0] d, d2;
    logic [3:0] prev, pat;
    repeat (5) @(negedge clk);
    chk(chanEn == 4'h0, "R9 reset enables", chanEn, 0);
    chk(sdaPullLow == 1'b0, "R9 reset SDA released", sdaPullLow, 0);
    chk(irqOutN == 1'b1, "R8 no interrupt", irqOutN, 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // sweep all selections, address pins and interrupt patterns
    prev = 4'h0;
    for (int v = 0; v < 16; v++) begin
      addrSel = v[1:0];
      pat = 4'(v * 7 + 3);
      irqN = pat;
      @(negedge clk);
      chk(irqOutN == (pat == 4'hF), "R8 summary output", irqOutN, (pat == 4'hF));
      busStart();
      sendByte(adr(addrSel, 1'b0), ack);
      chk(ack, "R1 write address ack", ack, 1);
      sendByte({4'(15 - v), 4'(v)}, ack);
      chk(ack, "R3 data ack", ack, 1);
      chk(chanEn == prev, "R5 held before STOP", chanEn, prev);
      busStop();
      chk(chanEn == 4'(v), "R4 selection applied", chanEn, v);
      prev = 4'(v);
      busStart();
      sendByte(adr(addrSel, 1'b1), ack);
      chk(ack, "R1 read address ack", ack, 1);
      getByte(d);
      sendBit(1'b1);
      waitQ();
      chk(sdaPullLow == 1'b0, "R7 released after NACK", sdaPullLow, 0);
      busStop();
      chk(d == {~pat, 4'(v)}, "R6 read value", d, {~pat, 4'(v)});
    end
    irqN = 4'hF;

    // R2 wrong pin bits and wrong fixed bits
    addrSel = 2'b01;
    busStart();
    sendByte(adr(2'b10, 1'b0), ack);
    chk(!ack, "R2 no ack on pin mismatch", ack, 0);
    sendByte(8'h00, ack);
    chk(!ack, "R2 following byte ignored", ack, 0);
    busStop();
    chk(chanEn == 4'hF, "R2 enables kept", chanEn, 15);
    busStart();
    sendByte({AFIX ^ 5'b10000, 2'b01, 1'b0}, ack);
    chk(!ack, "R2 no ack on fixed mismatch", ack, 0);
    busStop();

    // R3 several bytes, last kept
    busStart();
    sendByte(adr(addrSel, 1'b0), ack);
    sendByte(8'h03, ack);
    sendByte(8'h09, ack);
    sendByte(8'hF6, ack);
    chk(ack, "R3 third byte ack", ack, 1);
    busStop();
    chk(chanEn == 4'h6, "R3 last byte kept", chanEn, 6);

    // R5 repeated start keeps old selection
    busStart();
    sendByte(adr(addrSel, 1'b0), ack);
    sendByte(8'h0A, ack);
    busStart();
    sendByte(adr(addrSel, 1'b1), ack);
    getByte(d);
    sendBit(1'b1);
    chk(d[3:0] == 4'h6, "R5 read sees old selection", d[3:0], 6);
    chk(chanEn == 4'h6, "R5 not applied on repeated START", chanEn, 6);
    busStop();
    chk(chanEn == 4'hA, "R5 applied at later STOP", chanEn, 10);

    // R6/R7 capture timing and continuation
    irqN = 4'b1110;
    busStart();
    sendByte(adr(addrSel, 1'b1), ack);
    waitQ();
    irqN = 4'b0111;
    getByte(d);
    irqN = 4'b0101;
    sendBit(1'b0);
    getByte(d2);
    irqN = 4'b0000;
    sendBit(1'b1);
    getBit(b);
    chk(d == 8'h1A, "R6 first byte captured at load", d, 8'h1A);
    chk(d2 == 8'hAA, "R7 second byte after ACK", d2, 8'hAA);
    chk(b == 1'b1, "R7 quiet after NACK", b, 1);
    busStop();
    irqN = 4'hF;

    // R11 START inside a byte
    busStart();
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    busStart();
    sendByte(adr(addrSel, 1'b0), ack);
    chk(ack, "R11 address after abort", ack, 1);
    sendByte(8'h03, ack);
    busStop();
    chk(chanEn == 4'h3, "R11 write after abort", chanEn, 3);

    // R9 reset in the middle of a write
    busStart();
    sendByte(adr(addrSel, 1'b0), ack);
    sendByte(8'h0C, ack);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(chanEn == 4'h0, "R9 reset clears enables", chanEn, 0);
    rstN = 1'b1;
    busStop();
    chk(chanEn == 4'h0, "R9 pending dropped", chanEn, 0);

    chk(pullViol == 0, "R10 pull stable while SCL high", pullViol, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule